// File: doc/BRIEF.md
# Reset Source and Start-up Timer Controller

This block merges the reset sources of a small microcontroller into one chip reset and records why the last reset or wake-up happened. It takes a power-on pulse, an active-low external reset pin, a watchdog time-out strobe and a sleep-state flag. It drives a chip reset that returns the core's registers to their reset state. It also drives a one-cycle wake-up strobe and two status bits, `statTo` (time-out) and `statPd` (power-down), which software reads to tell the reset causes apart.

The external pin passes through a two-flop synchronizer and then a glitch filter. A pin pulse shorter than `FILT_LEN` main-clock cycles never reaches the core. Every accepted reset sets a hold state. The chip reset is then released through up to two start-up delays, run in a fixed order. The first is a power-up delay of `2**CNT_W` counts on a separate internal RC clock. The second is an oscillator start-up delay of `2**CNT_W` counts on the main oscillator clock. A delay whose enable is low is skipped.

A watchdog time-out during sleep does not reset anything. It only wakes the core so execution resumes. Only a rising supply produces the power-on pulse, so a falling supply has no reset path into this block.

Top module: `reset_seq_ctrl`

## Requirements
- R1: While `porPulse` is high, `chipRst` is 1, `wakeUp` is 0 and {statTo,statPd} = {1,1`}`; after the pulse ends the status stays {1,1} and `chipRst` stays 1 until the enabled delays expire.
- R2: With `pwrtEn` = 1, the released chip reset includes a delay of at least `2**CNT_W` periods of `rcClk`, counted in the `rcClk` domain; it runs before the oscillator delay.
- R3: With `ostEn` = 1, the oscillator delay lasts exactly `2**CNT_W` `oscClk` cycles, so a released external pin drops `chipRst` 4 + `2**CNT_W` cycles later (with `pwrtEn` = 0).
- R4: With both enables low, `chipRst` drops 2 cycles after a running watchdog time-out is sampled and 4 cycles after the external pin returns high.
- R5: The external pin is accepted only after it has been low for `FILT_LEN` consecutive synchronized cycles; a shorter low pulse never raises `chipRst`.
- R6: An external reset while running leaves {statTo,statPd} unchanged.
- R7: An external reset while `sleepActive` = 1 sets {statTo,statPd} = {1,0}.
- R8: A watchdog time-out while running and not asleep raises `chipRst` in the next cycle and sets {statTo,statPd} = {0,1}.
- R9: A watchdog time-out while asleep never raises `chipRst`; it gives a `wakeUp` pulse exactly one cycle long in the next cycle and sets {statTo,statPd} = {0,0}.
- R10: A rising edge of `sleepActive` while running sets {statTo,statPd} = {1,0} in the next cycle.
- R11: A `wdtClrCmd` strobe while running, awake and with no other event, sets {statTo,statPd} = {1,1} in the next cycle.
- R12: `chipRst` stays 1 for as long as the filtered external pin stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| oscClk | input | 1 | Main oscillator clock; clocks filter, sequencer and oscillator delay |
| rcClk | input | 1 | Independent internal RC clock for the power-up delay |
| porPulse | input | 1 | Power-on pulse, active high, asynchronous |
| extRstN | input | 1 | External reset pin, active low, asynchronous |
| wdtTimeout | input | 1 | Watchdog time-out strobe, one `oscClk` cycle |
| sleepActive | input | 1 | Core is in sleep |
| wdtClrCmd | input | 1 | Watchdog-clear command strobe |
| pwrtEn | input | 1 | Enable for the power-up delay |
| ostEn | input | 1 | Enable for the oscillator start-up delay |
| chipRst | output | 1 | Chip reset, active high |
| wakeUp | output | 1 | One-cycle wake-from-sleep strobe |
| statTo | output | 1 | Time-out status bit |
| statPd | output | 1 | Power-down status bit |

## Verification
The bench builds the block with `CNT_W` = 4 and `FILT_LEN` = 4. Each start-up delay then ends after 16 counts, so all four enable combinations can be swept through a running watchdog reset within a few hundred cycles. Release times on the main-clock path are checked to the exact cycle. The RC-clock path is checked against bounds derived from the two clock periods. The short filter lets every low pulse width from 1 to 6 cycles be tried, covering both sides of the acceptance threshold. All five reset causes are driven with their status encodings.

// File: rtl/reset_seq_pkg.sv
package reset_seq_pkg;

  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_PWRT = 2'd1,
    ST_OST  = 2'd2,
    ST_RUN  = 2'd3
  } seqState_e;

  // Strobes from the sequencer to the timer datapath.
  typedef struct packed {
    logic pwrtRun;
    logic ostRun;
  } tmrStrobe_t;

endpackage

// File: rtl/reset_seq_datapath.sv
module reset_seq_datapath
  import reset_seq_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int FILT_LEN = 4
) (
  input  logic       oscClk,
  input  logic       rcClk,
  input  logic       porPulse,
  input  logic       extRstN,
  input  tmrStrobe_t strobe,
  output logic       extHeld,
  output logic       pwrtDone,
  output logic       ostDone
);

  localparam int FW = $clog2(FILT_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [FW-1:0] FILT_LAST = FW'(FILT_LEN - 1);

  // Pin synchronizer, idles high (pin released).
  logic [1:0] pinSync;
  logic       pinLow;

  always_ff @(posedge oscClk or posedge porPulse) begin
    if (porPulse) pinSync <= 2'b11;
    else          pinSync <= {pinSync[0], extRstN};
  end

  assign pinLow = ~pinSync[1];

  // Glitch filter: accept after FILT_LEN consecutive low samples,
  // drop at once on the first high sample.
  logic [FW-1:0] lowCnt;

  always_ff @(posedge oscClk or posedge porPulse) begin
    if (porPulse) begin
      lowCnt  <= '0;
      extHeld <= 1'b0;
    end else if (!pinLow) begin
      lowCnt  <= '0;
      extHeld <= 1'b0;
    end else if (!extHeld) begin
      if (lowCnt == FILT_LAST) extHeld <= 1'b1;
      else                     lowCnt  <= lowCnt + 1'b1;
    end
  end

  // R5
  // filter_width_chk
  filter_width_chk: assert property (@(posedge oscClk) disable iff (porPulse)
    $rose(extHeld) |-> $past(pinLow));

  // Oscillator start-up delay on the main clock.
  logic [CNT_W-1:0] ostCnt;

  always_ff @(posedge oscClk or posedge porPulse) begin
    if (porPulse)               ostCnt <= '0;
    else if (!strobe.ostRun)    ostCnt <= '0;
    else if (ostCnt != CNT_MAX) ostCnt <= ostCnt + 1'b1;
  end

  assign ostDone = strobe.ostRun && (ostCnt == CNT_MAX);

  // Power-up delay on the RC clock; run request synchronized in.
  logic [1:0]       runSync;
  logic [CNT_W-1:0] pwrtCnt;
  logic             pwrtDoneRc;

  always_ff @(posedge rcClk or posedge porPulse) begin
    if (porPulse) begin
      runSync    <= 2'b00;
      pwrtCnt    <= '0;
      pwrtDoneRc <= 1'b0;
    end else begin
      runSync <= {runSync[0], strobe.pwrtRun};
      if (!runSync[1]) begin
        pwrtCnt    <= '0;
        pwrtDoneRc <= 1'b0;
      end else if (pwrtCnt == CNT_MAX) begin
        pwrtDoneRc <= 1'b1;
      end else begin
        pwrtCnt <= pwrtCnt + 1'b1;
      end
    end
  end

  // Done flag back into the main clock domain.
  logic [1:0] doneSync;

  always_ff @(posedge oscClk or posedge porPulse) begin
    if (porPulse) doneSync <= 2'b00;
    else          doneSync <= {doneSync[0], pwrtDoneRc};
  end

  assign pwrtDone = doneSync[1];

endmodule

// File: rtl/reset_seq_control.sv
module reset_seq_control
  import reset_seq_pkg::*;
(
  input  logic       oscClk,
  input  logic       porPulse,
  input  logic       wdtTimeout,
  input  logic       sleepActive,
  input  logic       wdtClrCmd,
  input  logic       pwrtEn,
  input  logic       ostEn,
  input  logic       extHeld,
  input  logic       pwrtDone,
  input  logic       ostDone,
  output tmrStrobe_t strobe,
  output logic       chipRst,
  output logic       wakeUp,
  output logic       statTo,
  output logic       statPd
);

  seqState_e state;
  seqState_e nextState;
  logic      extHeldQ;
  logic      sleepQ;
  logic      running;
  logic      extRise;
  logic      wdtRun;

  assign running = (state == ST_RUN);
  assign extRise = extHeld && !extHeldQ;
  assign wdtRun  = running && wdtTimeout;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_HOLD: if (!pwrtDone) begin
        if (pwrtEn)     nextState = ST_PWRT;
        else if (ostEn) nextState = ST_OST;
        else            nextState = ST_RUN;
      end
      ST_PWRT: if (pwrtDone) nextState = ostEn ? ST_OST : ST_RUN;
      ST_OST:  if (ostDone)  nextState = ST_RUN;
      ST_RUN:  if (wdtTimeout && !sleepActive) nextState = ST_HOLD;
      default: nextState = ST_HOLD;
    endcase
    if (extHeld) nextState = ST_HOLD;
  end

  always_ff @(posedge oscClk or posedge porPulse) begin
    if (porPulse) begin
      state    <= ST_HOLD;
      extHeldQ <= 1'b0;
      sleepQ   <= 1'b0;
      wakeUp   <= 1'b0;
    end else begin
      state    <= nextState;
      extHeldQ <= extHeld;
      sleepQ   <= sleepActive;
      wakeUp   <= wdtRun && sleepActive && !extHeld;
    end
  end

  // Status bits: reset cause and sleep bookkeeping for software.
  always_ff @(posedge oscClk or posedge porPulse) begin
    if (porPulse) begin
      statTo <= 1'b1;
      statPd <= 1'b1;
    end else if (extRise) begin
      if (sleepActive) begin
        statTo <= 1'b1;
        statPd <= 1'b0;
      end
    end else if (wdtRun) begin
      statTo <= 1'b0;
      statPd <= !sleepActive;
    end else if (running && sleepActive && !sleepQ) begin
      statTo <= 1'b1;
      statPd <= 1'b0;
    end else if (running && wdtClrCmd) begin
      statTo <= 1'b1;
      statPd <= 1'b1;
    end
  end

  assign chipRst        = !running;
  assign strobe.pwrtRun = (state == ST_PWRT);
  assign strobe.ostRun  = (state == ST_OST);

  // R9
  // sleep_wake_chk
  sleep_wake_chk: assert property (@(posedge oscClk) disable iff (porPulse)
    (running && sleepActive && wdtTimeout && !extHeld)
      |=> (!chipRst && wakeUp && !statTo && !statPd));

  // R8
  // wdt_reset_chk
  wdt_reset_chk: assert property (@(posedge oscClk) disable iff (porPulse)
    (running && !sleepActive && wdtTimeout && !extHeld)
      |=> (chipRst && !statTo && statPd));

  // R12
  // ext_hold_chk
  ext_hold_chk: assert property (@(posedge oscClk) disable iff (porPulse)
    extHeld |=> chipRst);

  // R3
  // ost_release_chk
  ost_release_chk: assert property (@(posedge oscClk) disable iff (porPulse)
    ($fell(chipRst) && $past(ostEn)) |-> $past(ostDone));

  // R11
  // wdt_clear_chk
  wdt_clear_chk: assert property (@(posedge oscClk) disable iff (porPulse)
    (running && wdtClrCmd && !wdtTimeout && !sleepActive && !extHeld)
      |=> (statTo && statPd));

endmodule

// File: rtl/reset_seq_ctrl.sv
module reset_seq_ctrl
  import reset_seq_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int FILT_LEN = 4
) (
  input  logic oscClk,
  input  logic rcClk,
  input  logic porPulse,
  input  logic extRstN,
  input  logic wdtTimeout,
  input  logic sleepActive,
  input  logic wdtClrCmd,
  input  logic pwrtEn,
  input  logic ostEn,
  output logic chipRst,
  output logic wakeUp,
  output logic statTo,
  output logic statPd
);

  tmrStrobe_t strobe;
  logic       extHeld;
  logic       pwrtDone;
  logic       ostDone;

  reset_seq_datapath #(
    .CNT_W   (CNT_W),
    .FILT_LEN(FILT_LEN)
  ) u_datapath (
    .oscClk  (oscClk),
    .rcClk   (rcClk),
    .porPulse(porPulse),
    .extRstN (extRstN),
    .strobe  (strobe),
    .extHeld (extHeld),
    .pwrtDone(pwrtDone),
    .ostDone (ostDone)
  );

  reset_seq_control u_control (
    .oscClk     (oscClk),
    .porPulse   (porPulse),
    .wdtTimeout (wdtTimeout),
    .sleepActive(sleepActive),
    .wdtClrCmd  (wdtClrCmd),
    .pwrtEn     (pwrtEn),
    .ostEn      (ostEn),
    .extHeld    (extHeld),
    .pwrtDone   (pwrtDone),
    .ostDone    (ostDone),
    .strobe     (strobe),
    .chipRst    (chipRst),
    .wakeUp     (wakeUp),
    .statTo     (statTo),
    .statPd     (statPd)
  );

endmodule

// File: tb/reset_seq_ctrl_bench.sv
`timescale 1ns/1ps
module reset_seq_ctrl_bench;

  localparam int BW      = 4;
  localparam int FL      = 4;
  localparam int TERM    = 1 << BW;
  localparam int OSC_PER = 5;
  localparam int RC_PER  = 14;

  logic oscClk = 1'b0;
  logic rcClk  = 1'b0;
  logic porPulse, extRstN, wdtTimeout, sleepActive, wdtClrCmd, pwrtEn, ostEn;
  logic chipRst, wakeUp, statTo, statPd;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(OSC_PER / 2.0) oscClk = ~oscClk;
  always #(RC_PER / 2.0) rcClk = ~rcClk;

  reset_seq_ctrl #(.CNT_W(BW), .FILT_LEN(FL)) u_reset_seq_ctrl (
    .oscClk(oscClk), .rcClk(rcClk), .porPulse(porPulse), .extRstN(extRstN),
    .wdtTimeout(wdtTimeout), .sleepActive(sleepActive), .wdtClrCmd(wdtClrCmd),
    .pwrtEn(pwrtEn), .ostEn(ostEn), .chipRst(chipRst), .wakeUp(wakeUp),
    .statTo(statTo), .statPd(statPd)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge oscClk);
  endtask

  task automatic pulseClr();
    wdtClrCmd = 1'b1;
    @(negedge oscClk);
    wdtClrCmd = 1'b0;
  endtask

  // Count posedges until chipRst is seen low at a negedge.
  task automatic waitRelease(inout int cyc);
    for (int i = 0; i < 400; i++) begin
      if (!chipRst) break;
      @(posedge oscClk);
      cyc++;
      @(negedge oscClk);
    end
  endtask

  task automatic checkRange(input int cyc, input int lo, input int hi, input string tag);
    check(cyc >= lo && cyc <= hi, tag, cyc, lo);
  endtask

  initial begin
    #(200000 * OSC_PER);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int cyc;
    porPulse = 1'b1; extRstN = 1'b1; wdtTimeout = 1'b0; sleepActive = 1'b0;
    wdtClrCmd = 1'b0; pwrtEn = 1'b1; ostEn = 1'b1;
    idle(5);
    // R1 reset state
    check(chipRst == 1'b1, "R1 chipRst in por", chipRst, 1);
    check(wakeUp == 1'b0, "R1 wakeUp in por", wakeUp, 0);
    check({statTo, statPd} == 2'b11, "R1 status in por", {statTo, statPd}, 3);
    porPulse = 1'b0;
    cyc = 0;
    waitRelease(cyc);
    // R2 R3 power-up then oscillator delay after power-on
    checkRange(cyc, (TERM * RC_PER) / OSC_PER + TERM,
               ((TERM + 4) * RC_PER) / OSC_PER + 8 + TERM, "R2 por release window");
    check({statTo, statPd} == 2'b11, "R1 status after por", {statTo, statPd}, 3);

    // Watchdog reset while running, all enable combinations.
    for (int e = 0; e < 4; e++) begin
      int lo, hi;
      pwrtEn = e[1];
      ostEn  = e[0];
      idle(30);
      wdtTimeout = 1'b1;
      @(posedge oscClk);
      @(negedge oscClk);
      wdtTimeout = 1'b0;
      check(chipRst == 1'b1, "R8 chipRst after wdt", chipRst, 1);
      cyc = 1;
      waitRelease(cyc);
      if (pwrtEn) begin
        lo = (TERM * RC_PER) / OSC_PER + (ostEn ? TERM : 0);
        hi = ((TERM + 4) * RC_PER) / OSC_PER + 8 + (ostEn ? TERM : 0);
        checkRange(cyc, lo, hi, "R2 wdt release with power-up delay");
      end else begin
        lo = 2 + (ostEn ? TERM : 0);
        check(cyc == lo, ostEn ? "R3 wdt release ost only" : "R4 wdt release no delay",
              cyc, lo);
      end
      check({statTo, statPd} == 2'b01, "R8 status after wdt", {statTo, statPd}, 1);
      pulseClr();
      check({statTo, statPd} == 2'b11, "R11 status after clear", {statTo, statPd}, 3);
    end

    pwrtEn = 1'b0;
    ostEn  = 1'b0;
    idle(30);

    // R10 sleep entry
    sleepActive = 1'b1;
    idle(1);
    check({statTo, statPd} == 2'b10, "R10 status on sleep", {statTo, statPd}, 2);

    // R9 watchdog wake-up
    wdtTimeout = 1'b1;
    @(negedge oscClk);
    wdtTimeout = 1'b0;
    check(wakeUp == 1'b1, "R9 wakeUp pulse", wakeUp, 1);
    check(chipRst == 1'b0, "R9 no chipRst on wake", chipRst, 0);
    @(negedge oscClk);
    check(wakeUp == 1'b0, "R9 wakeUp one cycle", wakeUp, 0);
    begin
      bit sawRst = 1'b0;
      for (int i = 0; i < 10; i++) begin
        if (chipRst) sawRst = 1'b1;
        @(negedge oscClk);
      end
      check(!sawRst, "R9 chipRst stays low", sawRst, 0);
    end
    check({statTo, statPd} == 2'b00, "R9 status on wake", {statTo, statPd}, 0);

    // R7 external reset while asleep
    extRstN = 1'b0;
    idle(30);
    check(chipRst == 1'b1, "R12 chipRst while pin low", chipRst, 1);
    check({statTo, statPd} == 2'b10, "R7 status ext asleep", {statTo, statPd}, 2);
    extRstN = 1'b1;
    cyc = 0;
    waitRelease(cyc);
    check(cyc == 4, "R4 ext release no delay", cyc, 4);
    sleepActive = 1'b0;
    idle(5);

    // R6 external reset while running keeps status (make it 0,1 first)
    wdtTimeout = 1'b1;
    @(negedge oscClk);
    wdtTimeout = 1'b0;
    cyc = 1;
    waitRelease(cyc);
    idle(5);
    extRstN = 1'b0;
    idle(10);
    check(chipRst == 1'b1, "R12 chipRst ext running", chipRst, 1);
    check({statTo, statPd} == 2'b01, "R6 status unchanged", {statTo, statPd}, 1);
    extRstN = 1'b1;
    cyc = 0;
    waitRelease(cyc);
    check({statTo, statPd} == 2'b01, "R6 status after release", {statTo, statPd}, 1);

    // R5 filter width sweep
    for (int len = 1; len <= 6; len++) begin
      bit sawRst = 1'b0;
      idle(10);
      extRstN = 1'b0;
      for (int i = 0; i < len; i++) begin
        @(negedge oscClk);
        if (chipRst) sawRst = 1'b1;
      end
      extRstN = 1'b1;
      for (int i = 0; i < 10; i++) begin
        @(negedge oscClk);
        if (chipRst) sawRst = 1'b1;
      end
      check(sawRst == (len >= FL), "R5 filter pulse width", sawRst, int'(len >= FL));
    end

    // R3 oscillator delay after external reset
    idle(10);
    ostEn = 1'b1;
    extRstN = 1'b0;
    idle(12);
    extRstN = 1'b1;
    cyc = 0;
    waitRelease(cyc);
    check(cyc == 4 + TERM, "R3 ext release ost only", cyc, 4 + TERM);

    idle(5);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule